// File: doc/BRIEF.md
# Masked Serial Command Shifter

The block sends short commands to peripherals over a three-wire serial link made of a bit clock, a data line and a frame enable. Software sees two 16-bit registers. The mask register selects which bit positions carry payload. The data register holds the bits to send. A write to the data register launches a transfer at once, so software loads the mask first.

During a transfer the data and mask registers rotate left together, once per bit period, for exactly one full word of periods. A period whose mask MSB is set puts the data MSB on the wire with one clock pulse. A period whose mask MSB is clear runs silently. After the last rotation both registers hold their written values again. Software can poll either register for completion, or watch the busy flag. Reads made mid-transfer show the partly rotated word.

A typical command uses mask 0x07FF. It carries a two-bit device address of binary 10 in bits 10:9 and nine payload bits below. For example, data 0x04C4 sends the eleven bits 100_1100_0100.

Top module: `serial_cmd_shifter`

## Requirements
- R1: After reset both registers read 0, busy_o is 0, and ser_clk_o, ser_dat_o and ser_en_o are all low.
- R2: While idle, wr_mask_i loads wdata_i into the mask register. wr_data_i loads wdata_i into the data register, and busy_o and ser_en_o are high from the next cycle on.
- R3: A transfer lasts exactly WIDTH*BIT_CYC cycles. ser_en_o equals busy_o throughout, and both drop together after the WIDTH-th rotation.
- R4: Once per bit period, both registers rotate left by one position (old bit WIDTH-1 moves to bit 0). After k completed periods, data_o and mask_o read the written values rotated left by k.
- R5: Exactly one clock pulse is emitted for each mask bit that is 1, and none for mask bits that are 0. The pulses carry the selected data bits MSB first.
- R6: In a period whose mask MSB is 1, ser_clk_o is low for the first BIT_CYC/2 cycles and high for the rest. ser_dat_o holds the data MSB for the whole period, so it changes only while the clock is low, at a falling edge.
- R7: When a transfer completes, data_o and mask_o equal the values that were written before it.
- R8: While busy_o is high, writes to either register are ignored. The transfer's bits and the final register values are unchanged.
- R9: While idle, ser_clk_o and ser_dat_o are low. In a period whose mask MSB is 0, both stay low.
- R10: A mask of 0 still gives a full-length transfer, with ser_en_o high and no clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wdata_i | input | WIDTH | Write data for either register |
| wr_mask_i | input | 1 | Mask register write strobe |
| wr_data_i | input | 1 | Data register write strobe, starts a transfer |
| data_o | output | WIDTH | Data register readback, rotating while busy |
| mask_o | output | WIDTH | Mask register readback, rotating while busy |
| busy_o | output | 1 | Transfer in progress |
| ser_clk_o | output | 1 | Serial bit clock |
| ser_dat_o | output | 1 | Serial data |
| ser_en_o | output | 1 | Frame enable, high for the whole transfer |

## Verification
The bench sends five commands. The typical 0x07FF/0x04C4 command checks the address-plus-payload framing and the MSB-first order. A full mask with a mixed data word separates a correct rotation from a shifted or reversed one. The sparse 0x8001 mask shows that skipped periods make no pulse while the frame length stays the same. An all-zero mask gives an enable frame with no clock at all. In the last transfer, writes to both registers are injected mid-frame; a correct design ignores them, while a design that accepts them changes the bits sent or the restored values.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int WORD_W  = 16;
  localparam int BIT_CYC = 8;   // system clocks per serial bit, even

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} half_e;
endpackage

// File: rtl/scs_bit_timer.sv
module scs_bit_timer
  import scs_pkg::*;
#(
  parameter int BIT_CYC = scs_pkg::BIT_CYC
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  output half_e phase_o,
  output logic  period_end_o
);
  localparam int CW   = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
  localparam int HALF = BIT_CYC / 2;

  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (!run_i)       cyc_q <= '0;
    else if (period_end_o) cyc_q <= '0;
    else                   cyc_q <= cyc_q + 1'b1;
  end

  assign period_end_o = run_i && (cyc_q == CW'(BIT_CYC - 1));
  assign phase_o      = (cyc_q >= CW'(HALF)) ? PH_HIGH : PH_LOW;
endmodule

// File: rtl/scs_rot_reg.sv
module scs_rot_reg #(
  parameter int WIDTH = scs_pkg::WORD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             rot_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= load_val_i;
    else if (rot_i)  q_o <= {q_o[WIDTH-2:0], q_o[WIDTH-1]};
  end
endmodule

// File: rtl/scs_frame_ctrl.sv
module scs_frame_ctrl #(
  parameter int WIDTH = scs_pkg::WORD_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic period_end_i,
  output logic busy_o
);
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;

  logic [CNT_W-1:0] bit_cnt_q;
  logic             last_bit;

  assign last_bit = (bit_cnt_q == CNT_W'(WIDTH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      bit_cnt_q <= '0;
    end else if (start_i) begin
      busy_o    <= 1'b1;
      bit_cnt_q <= '0;
    end else if (busy_o && period_end_i) begin
      if (last_bit) begin
        busy_o    <= 1'b0;
        bit_cnt_q <= '0;
      end else begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_cmd_shifter.sv
module serial_cmd_shifter
  import scs_pkg::*;
#(
  parameter int WIDTH   = scs_pkg::WORD_W,
  parameter int BIT_CYC = scs_pkg::BIT_CYC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             wr_mask_i,
  input  logic             wr_data_i,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] mask_o,
  output logic             busy_o,
  output logic             ser_clk_o,
  output logic             ser_dat_o,
  output logic             ser_en_o
);
  logic  start, mask_ld, rot, slot_on;
  half_e phase;

  // writes are accepted only while idle
  assign start   = wr_data_i && !busy_o;
  assign mask_ld = wr_mask_i && !busy_o;

  scs_frame_ctrl #(.WIDTH(WIDTH)) u_frame (
    .clk_i, .rst_ni,
    .start_i(start), .period_end_i(rot), .busy_o(busy_o)
  );

  scs_bit_timer #(.BIT_CYC(BIT_CYC)) u_timer (
    .clk_i, .rst_ni,
    .run_i(busy_o), .phase_o(phase), .period_end_o(rot)
  );

  scs_rot_reg #(.WIDTH(WIDTH)) u_data (
    .clk_i, .rst_ni,
    .load_i(start), .load_val_i(wdata_i), .rot_i(rot), .q_o(data_o)
  );

  scs_rot_reg #(.WIDTH(WIDTH)) u_mask (
    .clk_i, .rst_ni,
    .load_i(mask_ld), .load_val_i(wdata_i), .rot_i(rot), .q_o(mask_o)
  );

  assign slot_on   = busy_o && mask_o[WIDTH-1];
  assign ser_clk_o = slot_on && (phase == PH_HIGH);
  assign ser_dat_o = slot_on && data_o[WIDTH-1];
  assign ser_en_o  = busy_o;
endmodule

// File: rtl/scs_checker.sv
module scs_checker #(
  parameter int WIDTH = scs_pkg::WORD_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] wdata_i,
  input logic             wr_mask_i,
  input logic             wr_data_i,
  input logic [WIDTH-1:0] data_o,
  input logic [WIDTH-1:0] mask_o,
  input logic             busy_o,
  input logic             ser_clk_o,
  input logic             ser_dat_o,
  input logic             ser_en_o
);
  logic [WIDTH-1:0] cap_d, cap_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_d <= '0;
      cap_m <= '0;
    end else if (!busy_o) begin
      if (wr_data_i) cap_d <= wdata_i;
      if (wr_mask_i) cap_m <= wdata_i;
      else           cap_m <= mask_o;
    end
  end

  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && wr_data_i |=> busy_o && ser_en_o && data_o == $past(wdata_i));

  a_r3_clk_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_clk_o |-> ser_en_o && busy_o);

  a_r6_dat_stable_clk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_clk_o && $past(ser_clk_o) |-> $stable(ser_dat_o));

  a_r7_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> data_o == cap_d && mask_o == cap_m);

  a_r8_rot_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) && busy_o && data_o != $past(data_o)
      |-> data_o == {$past(data_o[WIDTH-2:0]), $past(data_o[WIDTH-1])});

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ser_clk_o && !ser_dat_o && !ser_en_o);
endmodule

bind serial_cmd_shifter scs_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_serial_cmd_shifter.sv
module tb_serial_cmd_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int BIT_CYC = 8;
  localparam int HALF = BIT_CYC / 2;

  logic         clk_i = 0, rst_ni = 0;
  logic [W-1:0] wdata_i = '0;
  logic         wr_mask_i = 0, wr_data_i = 0;
  logic [W-1:0] data_o, mask_o;
  logic         busy_o, ser_clk_o, ser_dat_o, ser_en_o;

  int n_chk = 0, n_fail = 0, pulses = 0;
  bit exp_q[$];
  logic prev_sclk = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  serial_cmd_shifter #(.WIDTH(W), .BIT_CYC(BIT_CYC)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int k);
    logic [W-1:0] r = v;
    for (int i = 0; i < k; i++) r = {r[W-2:0], r[W-1]};
    return r;
  endfunction

  // monitor: pops an expected bit on every rising serial clock (R5)
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (ser_clk_o && !prev_sclk) begin
        pulses++;
        if (exp_q.size() == 0) chk(0, "R5", "unexpected pulse", 1, 0);
        else begin
          bit b;
          b = exp_q.pop_front();
          chk(b == ser_dat_o, "R5", "bit value", ser_dat_o, b);
        end
      end
      prev_sclk <= ser_clk_o;
    end
  end

  task automatic wr_mask(input logic [W-1:0] v);
    @(negedge clk_i); wdata_i = v; wr_mask_i = 1;
    @(negedge clk_i); wr_mask_i = 0;
    chk(mask_o == v, "R2", "mask load", mask_o, v);
  endtask

  task automatic send(input logic [W-1:0] m, input logic [W-1:0] d, input bit poke);
    int bad3 = 0, bad4 = 0, bad6 = 0, pc = 0;
    for (int i = W - 1; i >= 0; i--) if (m[i]) begin exp_q.push_back(d[i]); pc++; end
    pulses = 0;
    @(negedge clk_i); wdata_i = d; wr_data_i = 1;
    @(negedge clk_i); wr_data_i = 0;
    chk(busy_o && ser_en_o && data_o == d, "R2", "start", {busy_o, ser_en_o, data_o}, {2'b11, d});
    for (int t = 0; t < W * BIT_CYC; t++) begin
      logic [W-1:0] mr, dr;
      logic ec, ed;
      mr = rotl(m, t / BIT_CYC);
      dr = rotl(d, t / BIT_CYC);
      ec = mr[W-1] && ((t % BIT_CYC) >= HALF);
      ed = mr[W-1] && dr[W-1];
      if (ser_clk_o !== ec || ser_dat_o !== ed) bad6++;
      if (busy_o !== 1'b1 || ser_en_o !== 1'b1) bad3++;
      if (data_o !== dr || mask_o !== mr) bad4++;
      if (poke && t == 20) begin
        wdata_i = 16'hFFFF; wr_data_i = 1; wr_mask_i = 1;
      end else begin
        wr_data_i = 0; wr_mask_i = 0;
      end
      @(negedge clk_i);
    end
    chk(bad6 == 0, "R6", "clock/data waveform", bad6, 0);
    chk(bad3 == 0 && !busy_o && !ser_en_o, "R3", "frame length", bad3, 0);
    chk(bad4 == 0, "R4", "rotating readback", bad4, 0);
    chk(data_o == d && mask_o == m, poke ? "R8" : "R7", "restored regs",
        {data_o, mask_o}, {d, m});
    chk(exp_q.size() == 0 && pulses == pc, m == 0 ? "R10" : "R5", "pulse count", pulses, pc);
    chk(!ser_clk_o && !ser_dat_o, "R9", "idle lines", {ser_clk_o, ser_dat_o}, 0);
    exp_q.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(data_o == 0 && mask_o == 0 && !busy_o && !ser_clk_o && !ser_dat_o && !ser_en_o,
        "R1", "reset state", {data_o, mask_o}, 0);
    rst_ni = 1;
    wr_mask(16'h07FF); send(16'h07FF, 16'h04C4, 0);
    wr_mask(16'hFFFF); send(16'hFFFF, 16'hA5C3, 0);
    wr_mask(16'h8001); send(16'h8001, 16'h8001, 0);
    wr_mask(16'h0000); send(16'h0000, 16'h1234, 0);  // R10
    wr_mask(16'hAAAA); send(16'hAAAA, 16'h5555, 1);  // R8
    repeat (4) @(negedge clk_i);
    chk(!ser_clk_o && !ser_dat_o && !busy_o, "R9", "final idle", {ser_clk_o, ser_dat_o}, 0);
    summary();
    $finish;
  end
endmodule